// File: doc/BRIEF.md
# Tear-Free Paired Register File

This block is a byte-wide register file covering a flat 256-byte address space. The lowest 32 bytes hold three kinds of register: 16-bit measurement pairs, one status byte and one control byte. Everything from address 32 upward is plain read/write storage. Internal measurement logic refreshes each 16-bit pair at any time. A host reaches the space one byte at a time and frames each transaction with a command-active level.

A 16-bit value read as two bytes can tear if an update lands between the two byte reads. To prevent this, a read of a pair's high byte during an active command copies both bytes into a per-pair holding register. A later read of the low byte in the same command returns the held byte. When the command ends, the hold is dropped.

The status byte collects event flags raised by internal logic. A flag stays set until the host writes a 0 to that bit.

Top module: `pairlock_regfile`

## Requirements
- R1: Address map with NPAIR=4. Pair i has its high byte at address 2i and its low byte at 2i+1. Status is at 8, control is at 9 and general storage is at 32..255. All other addresses below 32 read as 0 and ignore writes.
- R2: `host_rdata` shows the addressed byte on the clock edge after `host_re` is sampled high. It keeps its value while no read occurs.
- R3: A read of a high-byte address while `cmd_active` is high captures both bytes of that pair. The captured values are the ones present before any update in that same cycle. Each such read captures again.
- R4: After that capture, reads of the pair's low byte in the same command return the captured byte, even if the pair is updated in between.
- R5: When `cmd_active` is low, the hold is released and low-byte reads return the live value. A low-byte read with no earlier high-byte read in the current command also returns the live value.
- R6: `meas_upd[i]` loads `meas_val[16i+15:16i]` into pair i, visible from the next cycle. Host writes to pair addresses have no effect.
- R7: A status bit is set by a 1 on `status_set` and cleared only when the host writes 0 to it. Host writes of 1 leave the bit unchanged. A set in the same cycle as a clear wins.
- R8: The control byte is read/write by the host and drives `ctrl_q` from the cycle after the write.
- R9: Reset clears every register, hold, storage byte, `host_rdata` and `ctrl_q` to 0.
- R10: General storage bytes return the value last written by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_active | input | 1 | High for the duration of one host command |
| host_re | input | 1 | Host byte read strobe |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| meas_upd | input | NPAIR | Per-pair internal update strobes |
| meas_val | input | 16*NPAIR | Per-pair internal update values |
| status_set | input | 8 | Internal status set pulses |
| ctrl_q | output | 8 | Control byte contents |

## Verification
Every read result arrives on the first edge after the strobe is sampled. The bench therefore drives each operation at a falling edge and compares `host_rdata` at the next falling edge.

Updates, captures, status sets and writes are applied at that same edge, so their effect shows on the next operation. The bench model advances its state once per cycle in that order, using pre-edge values for the read.

`ctrl_q` is compared on every cycle, one edge after the write.

// File: rtl/pairlock_regfile.sv
module pairlock_regfile #(
  parameter int NPAIR    = 4,
  parameter int RAM_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_active,
  input  logic               host_re,
  input  logic               host_we,
  input  logic [7:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic [NPAIR-1:0]   meas_upd,
  input  logic [16*NPAIR-1:0] meas_val,
  input  logic [7:0]         status_set,
  output logic [7:0]         ctrl_q
);
  localparam int STAT_A = 2 * NPAIR;
  localparam int CTRL_A = STAT_A + 1;
  localparam int RAM_N  = 256 - RAM_BASE;
  localparam int PW     = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [15:0]      live_q [NPAIR];
  logic [15:0]      hold_q [NPAIR];
  logic [NPAIR-1:0] held_q;
  logic [7:0]       stat_q;
  logic [7:0]       ram_q [RAM_N];
  logic [7:0]       rd_next;

  wire          in_pair  = host_addr < 8'(STAT_A);
  wire [PW-1:0] pidx     = host_addr[PW:1];
  wire          is_stat  = host_addr == 8'(STAT_A);
  wire          is_ctrl  = host_addr == 8'(CTRL_A);
  wire          is_ram   = host_addr >= 8'(RAM_BASE);
  wire          is_rsv   = !in_pair && !is_stat && !is_ctrl && !is_ram;
  wire [7:0]    ram_idx  = host_addr - 8'(RAM_BASE);
  wire [7:0]    clr_mask = (host_we && is_stat) ? ~host_wdata : 8'h00;

  always_comb begin
    rd_next = 8'h00;
    if (in_pair) begin
      if (!host_addr[0])
        rd_next = live_q[pidx][15:8];
      else if (cmd_active && held_q[pidx])
        rd_next = hold_q[pidx][7:0];
      else
        rd_next = live_q[pidx][7:0];
    end else if (is_stat) rd_next = stat_q;
    else if (is_ctrl)     rd_next = ctrl_q;
    else if (is_ram)      rd_next = ram_q[ram_idx];
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    wire msb_hit = host_re && cmd_active && host_addr == 8'(2 * g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[g] <= '0;
        hold_q[g] <= '0;
        held_q[g] <= 1'b0;
      end else begin
        if (!cmd_active) held_q[g] <= 1'b0;
        else if (msb_hit) begin
          held_q[g] <= 1'b1;
          hold_q[g] <= live_q[g];
        end
        if (meas_upd[g]) live_q[g] <= meas_val[16*g +: 16];
      end
    end

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      held_q[g] && cmd_active && !msb_hit |=> $stable(hold_q[g])); // R4
    AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_active |=> !held_q[g]); // R5
    AST_PAIR_RO: assert property (@(posedge clk) disable iff (!rst_n)
      host_we && (host_addr >> 1) == 8'(g) && !meas_upd[g] |=> $stable(live_q[g])); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      ctrl_q     <= '0;
      host_rdata <= '0;
      for (int i = 0; i < RAM_N; i++) ram_q[i] <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | status_set;
      if (host_we && is_ctrl) ctrl_q <= host_wdata;
      if (host_we && is_ram)  ram_q[ram_idx] <= host_wdata;
      if (host_re) host_rdata <= rd_next;
    end
  end

  AST_STAT_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(status_set)) == 8'h00); // R7
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(stat_q) & ~stat_q & ~$past(clr_mask)) == 8'h00); // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_re && is_rsv |=> host_rdata == 8'h00); // R1
  AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> $stable(host_rdata)); // R2
endmodule

// File: tb/pairlock_regfile_tb.sv
`timescale 1ns/1ps
module pairlock_regfile_tb;
  localparam int NP = 4;
  logic clk = 0, rst_n = 0, cmd_active = 0, host_re = 0, host_we = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, status_set = 0;
  logic [7:0] host_rdata, ctrl_q;
  logic [NP-1:0] meas_upd = 0;
  logic [16*NP-1:0] meas_val = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pairlock_regfile #(.NPAIR(NP), .RAM_BASE(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_active(cmd_active), .host_re(host_re),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .meas_upd(meas_upd), .meas_val(meas_val),
    .status_set(status_set), .ctrl_q(ctrl_q));

  logic [15:0] m_live [NP];
  logic [15:0] m_hold [NP];
  logic [NP-1:0] m_held;
  logic [7:0] m_stat, m_ctrl, m_rd;
  logic [7:0] m_ram [256];

  function automatic logic [7:0] exp_read(logic [7:0] a, logic cmd);
    if (a < 8'(2*NP)) begin
      if (!a[0]) return m_live[a>>1][15:8];
      if (cmd && m_held[a>>1]) return m_hold[a>>1][7:0];
      return m_live[a>>1][7:0];
    end
    if (a == 8'(2*NP))   return m_stat;
    if (a == 8'(2*NP+1)) return m_ctrl;
    if (a >= 8'd32)      return m_ram[a];
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic cmd, logic re, logic we, logic [7:0] a,
                      logic [7:0] wd, logic [NP-1:0] upd, logic [16*NP-1:0] vals,
                      logic [7:0] sset);
    cmd_active = cmd; host_re = re; host_we = we; host_addr = a;
    host_wdata = wd; meas_upd = upd; meas_val = vals; status_set = sset;
    if (re) m_rd = exp_read(a, cmd);
    for (int i = 0; i < NP; i++) begin
      if (!cmd) m_held[i] = 1'b0;
      else if (re && a == 8'(2*i)) begin m_held[i] = 1'b1; m_hold[i] = m_live[i]; end
    end
    for (int i = 0; i < NP; i++) if (upd[i]) m_live[i] = vals[16*i +: 16];
    m_stat = (m_stat & ((we && a == 8'(2*NP)) ? wd : 8'hFF)) | sset;
    if (we && a == 8'(2*NP+1)) m_ctrl = wd;
    if (we && a >= 8'd32) m_ram[a] = wd;
    @(posedge clk); @(negedge clk);
    chk({tag, " rdata"}, host_rdata, m_rd);
    chk("R8 ctrl_q", ctrl_q, m_ctrl);
  endtask

  function automatic logic [16*NP-1:0] pv(int i, logic [15:0] v);
    logic [16*NP-1:0] r = '0;
    r[16*i +: 16] = v;
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NP; i++) begin m_live[i] = 0; m_hold[i] = 0; end
    for (int i = 0; i < 256; i++) m_ram[i] = 0;
    m_held = 0; m_stat = 0; m_ctrl = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R9 rdata after reset", host_rdata, 8'h00);
    chk("R9 ctrl_q after reset", ctrl_q, 8'h00);
    step("R9 status reset", 0, 1, 0, 8'd8, 0, 0, 0, 0);
    step("R9 pair reset", 0, 1, 0, 8'd3, 0, 0, 0, 0);
    step("R9 ram reset", 0, 1, 0, 8'd200, 0, 0, 0, 0);
    step("R6 update", 1, 0, 0, 0, 0, 4'b0010, pv(1, 16'hA1B2), 0);
    step("R3 msb read", 1, 1, 0, 8'd2, 0, 0, 0, 0);
    step("R4 update during hold", 1, 0, 0, 0, 0, 4'b0010, pv(1, 16'hC3D4), 0);
    step("R4 lsb from hold", 1, 1, 0, 8'd3, 0, 0, 0, 0);
    step("R2 idle keeps rdata", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R5 cmd low", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5 lsb live after release", 0, 1, 0, 8'd3, 0, 0, 0, 0);
    step("R6 update pair2", 1, 0, 0, 0, 0, 4'b0100, pv(2, 16'h5566), 0);
    step("R5 lsb without msb", 1, 1, 0, 8'd5, 0, 0, 0, 0);
    step("R3 capture pre-update", 1, 1, 0, 8'd0, 0, 4'b0001, pv(0, 16'h1111), 0);
    step("R3 lsb old value", 1, 1, 0, 8'd1, 0, 0, 0, 0);
    step("R3 re-latch", 1, 1, 0, 8'd0, 0, 0, 0, 0);
    step("R3 lsb new value", 1, 1, 0, 8'd1, 0, 0, 0, 0);
    step("R6 host write pair", 0, 0, 1, 8'd1, 8'hEE, 0, 0, 0);
    step("R6 pair unchanged", 0, 1, 0, 8'd1, 0, 0, 0, 0);
    step("R7 set", 0, 0, 0, 0, 0, 0, 0, 8'h81);
    step("R7 write ones", 0, 1, 1, 8'd8, 8'hFF, 0, 0, 0);
    step("R7 write ones no effect", 0, 1, 0, 8'd8, 0, 0, 0, 0);
    step("R7 clear bit7", 0, 0, 1, 8'd8, 8'h7F, 0, 0, 0);
    step("R7 after clear", 0, 1, 0, 8'd8, 0, 0, 0, 0);
    step("R7 set wins", 0, 0, 1, 8'd8, 8'h00, 0, 0, 8'h01);
    step("R7 after set-clear", 0, 1, 0, 8'd8, 0, 0, 0, 0);
    step("R1 reserved write", 0, 0, 1, 8'd20, 8'h5A, 0, 0, 0);
    step("R1 reserved read", 0, 1, 0, 8'd20, 0, 0, 0, 0);
    step("R8 ctrl write", 0, 0, 1, 8'd9, 8'h3C, 0, 0, 0);
    step("R8 ctrl read", 0, 1, 0, 8'd9, 0, 0, 0, 0);
    step("R10 ram write", 0, 0, 1, 8'd255, 8'h99, 0, 0, 0);
    step("R10 ram read", 0, 1, 0, 8'd255, 0, 0, 0, 0);
    begin
      logic cmd = 0;
      for (int n = 0; n < 4000; n++) begin
        logic [7:0] a;
        logic re, we;
        logic [7:0] ss;
        if ($urandom_range(7) == 0) cmd = ~cmd;
        a  = ($urandom_range(9) < 7) ? 8'($urandom_range(11)) : 8'($urandom);
        re = $urandom_range(9) < 6;
        we = $urandom_range(9) < 3;
        ss = ($urandom_range(7) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
        step("R1-map/R3/R4/R5/R7/R10 random", cmd, re, we, a, 8'($urandom),
             NP'($urandom), {$urandom, $urandom}, ss);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule